// File: doc/BRIEF.md
# Two-Tier Hub Route Decision

This block picks the next routing stage for a packet sitting at one node of a 64-node, two-level on-chip network. The nodes are grouped into four sections of sixteen. Each section has a single hub router at one of its corner positions, and every hub links directly to the other three hubs. Traffic that stays inside a section moves under the in-section routing alone. Traffic bound for another section always climbs to its own section's hub, crosses the upper tier to the hub of the target section, and then descends to the final node. It does not take a shorter path that would bypass the hubs.

For each offered request the block compares the current node and the destination node. It returns a 2-bit routing-mode tag and the local index that the in-section routing table should steer toward. When the current node is a hub sending across the upper tier, it also returns which of the three hub-to-hub ports to use. The in-section routing table sits outside this block and is addressed with the effective local destination. Every result is registered and appears one clock after the request is accepted.

Top module: `tier_route_sel`

## Requirements
- R1: While reset is low at a clock edge, the outputs go to out_valid=0, out_mode=0, out_eff_dst=0 and out_up_port=0.
- R2: A valid request whose current section (id bits [5:4]) equals the destination section, with pkt_glob=0, gives out_mode=0 (local) and out_eff_dst equal to destination bits [3:0] on the next clock.
- R3: A valid request whose sections differ, at a node whose local index (bits [3:0]) is not HUB_IDX (default 0), gives out_mode=1 (to-hub) and out_eff_dst=HUB_IDX on the next clock.
- R4: A valid request whose sections differ, at the hub node, gives out_mode=2 (upper tier) and an out_up_port computed from the destination section d and current section c. The port is d when d<c and d-1 when d>c. The out_eff_dst is the destination local index.
- R5: A valid request whose sections match, with pkt_glob=1, gives out_mode=3 (descend) and out_eff_dst equal to the destination local index. This also holds at the hub itself.
- R6: out_up_port is 0 whenever out_mode is not 2.
- R7: Every valid request produces out_valid=1 on the next clock. A cycle with in_valid=0 gives out_valid=0 on the next clock, and out_mode, out_eff_dst and out_up_port keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| cur_id | input | 6 | Node holding the packet: section in [5:4], local index in [3:0] |
| dst_id | input | 6 | Final destination node, same layout |
| pkt_glob | input | 1 | Packet came from another section (descent phase) |
| out_valid | output | 1 | Registered result valid |
| out_mode | output | 2 | 0 local, 1 to-hub, 2 upper tier, 3 descend |
| out_eff_dst | output | 4 | Local index handed to the in-section routing table |
| out_up_port | output | 2 | Hub-to-hub port, meaningful in mode 2 only |

## Verification
The hub test and the section-match test can both be true in the same cycle. This happens when the packet sits at a hub and its destination lies in that hub's own section, with pkt_glob either 0 or 1. It also happens when the destination is the hub itself. The bench provokes this case with directed requests at every hub for every local destination, and again during a full sweep of all current/destination pairs. The section-match outcome must win: the result must be local or descend with the real local index, and it must never be the upper tier.

// File: rtl/tier_route_pkg.sv
// Shared types for the two-tier route decision.
// Assumes a 2-bit mode tag is enough for the four routing stages.
package tier_route_pkg;

    typedef enum logic [1:0] {
        MODE_LOCAL   = 2'd0,
        MODE_TO_HUB  = 2'd1,
        MODE_UPPER   = 2'd2,
        MODE_DESCEND = 2'd3
    } route_mode_e;

endpackage

// File: rtl/tier_id_split.sv
// Splits current and destination node ids into section and local index,
// and flags section match and hub position.
// Assumes ids are {section, local} with the section in the high bits.
module tier_id_split #(
    parameter int NUM_SEC   = 4,
    parameter int SEC_NODES = 16,
    parameter int HUB_IDX   = 0
) (
    input  logic [$clog2(NUM_SEC)+$clog2(SEC_NODES)-1:0] cur_id_i,
    input  logic [$clog2(NUM_SEC)+$clog2(SEC_NODES)-1:0] dst_id_i,
    output logic [$clog2(NUM_SEC)-1:0]                   cur_sec_o,
    output logic [$clog2(NUM_SEC)-1:0]                   dst_sec_o,
    output logic [$clog2(SEC_NODES)-1:0]                 dst_loc_o,
    output logic                                         same_sec_o,
    output logic                                         at_hub_o
);
    localparam int SEC_W = $clog2(NUM_SEC);
    localparam int LOC_W = $clog2(SEC_NODES);
    localparam int ID_W  = SEC_W + LOC_W;

    // Field extraction for both ids.
    assign cur_sec_o = cur_id_i[ID_W-1:LOC_W];
    assign dst_sec_o = dst_id_i[ID_W-1:LOC_W];
    assign dst_loc_o = dst_id_i[LOC_W-1:0];

    // Section comparison and hub detection.
    assign same_sec_o = (cur_id_i[ID_W-1:LOC_W] == dst_id_i[ID_W-1:LOC_W]);
    assign at_hub_o   = (cur_id_i[LOC_W-1:0] == LOC_W'(HUB_IDX));
endmodule

// File: rtl/tier_uplink_map.sv
// Maps a destination section to one of the NUM_SEC-1 hub-to-hub ports,
// skipping the hub's own section so the port codes stay dense.
// Assumes dst_sec differs from cur_sec when the result is used.
module tier_uplink_map #(
    parameter int NUM_SEC = 4
) (
    input  logic [$clog2(NUM_SEC)-1:0]                       cur_sec_i,
    input  logic [$clog2(NUM_SEC)-1:0]                       dst_sec_i,
    output logic [((NUM_SEC > 2) ? $clog2(NUM_SEC-1) : 1)-1:0] port_o
);
    localparam int SEC_W = $clog2(NUM_SEC);
    localparam int UPP_W = (NUM_SEC > 2) ? $clog2(NUM_SEC-1) : 1;

    logic [NUM_SEC-1:0] hit;
    logic [UPP_W-1:0]   code [NUM_SEC];

    // One candidate code per possible destination section.
    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        localparam int BELOW_CODE = s;
        localparam int ABOVE_CODE = (s > 0) ? s - 1 : 0;
        assign hit[s]  = (dst_sec_i == SEC_W'(s)) && (cur_sec_i != SEC_W'(s));
        assign code[s] = (SEC_W'(s) < cur_sec_i) ? UPP_W'(BELOW_CODE)
                                                 : UPP_W'(ABOVE_CODE);
    end

    // Merge the single selected candidate into the port code.
    always_comb begin
        port_o = '0;
        for (int s = 0; s < NUM_SEC; s++) begin
            if (hit[s]) port_o = port_o | code[s];
        end
    end
endmodule

// File: rtl/tier_mode_decide.sv
// Chooses the routing stage and effective local destination.
// Section match wins over hub position; only a hub with a foreign
// destination goes to the upper tier.
module tier_mode_decide #(
    parameter int SEC_NODES = 16,
    parameter int HUB_IDX   = 0,
    parameter int UPP_W     = 2
) (
    input  logic                          same_sec_i,
    input  logic                          at_hub_i,
    input  logic                          glob_i,
    input  logic [$clog2(SEC_NODES)-1:0]  dst_loc_i,
    input  logic [UPP_W-1:0]              map_port_i,
    output tier_route_pkg::route_mode_e   mode_o,
    output logic [$clog2(SEC_NODES)-1:0]  eff_dst_o,
    output logic [UPP_W-1:0]              up_port_o
);
    import tier_route_pkg::*;
    localparam int LOC_W = $clog2(SEC_NODES);

    // Stage selection with section match taking priority.
    always_comb begin
        mode_o    = MODE_LOCAL;
        eff_dst_o = dst_loc_i;
        up_port_o = '0;
        if (same_sec_i) begin
            mode_o = glob_i ? MODE_DESCEND : MODE_LOCAL;
        end else if (at_hub_i) begin
            mode_o    = MODE_UPPER;
            up_port_o = map_port_i;
        end else begin
            mode_o    = MODE_TO_HUB;
            eff_dst_o = LOC_W'(HUB_IDX);
        end
    end
endmodule

// File: rtl/tier_route_sel.sv
// Top of the two-tier route decision. Splits ids, maps the upper-tier
// port, decides the stage and registers the result for one cycle.
// Assumes a synchronous active-low reset; idle cycles hold the payload.
module tier_route_sel #(
    parameter int NUM_SEC   = 4,
    parameter int SEC_NODES = 16,
    parameter int HUB_IDX   = 0
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         in_valid,
    input  logic [$clog2(NUM_SEC)+$clog2(SEC_NODES)-1:0] cur_id,
    input  logic [$clog2(NUM_SEC)+$clog2(SEC_NODES)-1:0] dst_id,
    input  logic                                         pkt_glob,
    output logic                                         out_valid,
    output logic [1:0]                                   out_mode,
    output logic [$clog2(SEC_NODES)-1:0]                 out_eff_dst,
    output logic [((NUM_SEC > 2) ? $clog2(NUM_SEC-1) : 1)-1:0] out_up_port
);
    import tier_route_pkg::*;
    localparam int SEC_W = $clog2(NUM_SEC);
    localparam int LOC_W = $clog2(SEC_NODES);
    localparam int UPP_W = (NUM_SEC > 2) ? $clog2(NUM_SEC-1) : 1;

    logic [SEC_W-1:0] cur_sec, dst_sec;
    logic [LOC_W-1:0] dst_loc, nxt_eff;
    logic             same_sec, at_hub;
    logic [UPP_W-1:0] map_port, nxt_port;
    route_mode_e      nxt_mode;

    tier_id_split #(
        .NUM_SEC(NUM_SEC), .SEC_NODES(SEC_NODES), .HUB_IDX(HUB_IDX)
    ) u_split (
        .cur_id_i(cur_id), .dst_id_i(dst_id),
        .cur_sec_o(cur_sec), .dst_sec_o(dst_sec), .dst_loc_o(dst_loc),
        .same_sec_o(same_sec), .at_hub_o(at_hub)
    );

    tier_uplink_map #(.NUM_SEC(NUM_SEC)) u_map (
        .cur_sec_i(cur_sec), .dst_sec_i(dst_sec), .port_o(map_port)
    );

    tier_mode_decide #(
        .SEC_NODES(SEC_NODES), .HUB_IDX(HUB_IDX), .UPP_W(UPP_W)
    ) u_decide (
        .same_sec_i(same_sec), .at_hub_i(at_hub), .glob_i(pkt_glob),
        .dst_loc_i(dst_loc), .map_port_i(map_port),
        .mode_o(nxt_mode), .eff_dst_o(nxt_eff), .up_port_o(nxt_port)
    );

    // Valid flag follows the request every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Payload registers load only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mode    <= 2'(MODE_LOCAL);
            out_eff_dst <= '0;
            out_up_port <= '0;
        end else if (in_valid) begin
            out_mode    <= 2'(nxt_mode);
            out_eff_dst <= nxt_eff;
            out_up_port <= nxt_port;
        end
    end
endmodule

// File: rtl/tier_route_sel_chk.sv
// Checker for tier_route_sel; attached by bind below.
module tier_route_sel_chk #(
    parameter int NUM_SEC   = 4,
    parameter int SEC_NODES = 16,
    parameter int HUB_IDX   = 0
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         in_valid,
    input logic [$clog2(NUM_SEC)+$clog2(SEC_NODES)-1:0] cur_id,
    input logic [$clog2(NUM_SEC)+$clog2(SEC_NODES)-1:0] dst_id,
    input logic                                         pkt_glob,
    input logic                                         out_valid,
    input logic [1:0]                                   out_mode,
    input logic [$clog2(SEC_NODES)-1:0]                 out_eff_dst,
    input logic [((NUM_SEC > 2) ? $clog2(NUM_SEC-1) : 1)-1:0] out_up_port
);
    localparam int LOC_W = $clog2(SEC_NODES);
    localparam int ID_W  = $clog2(NUM_SEC) + LOC_W;

    logic same, hub;
    assign same = (cur_id[ID_W-1:LOC_W] == dst_id[ID_W-1:LOC_W]);
    assign hub  = (cur_id[LOC_W-1:0] == LOC_W'(HUB_IDX));

    p_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && same && !pkt_glob |=>
            out_mode == 2'd0 && out_eff_dst == $past(dst_id[LOC_W-1:0]));

    p_tohub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !same && !hub |=>
            out_mode == 2'd1 && out_eff_dst == LOC_W'(HUB_IDX));

    p_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !same && hub |=>
            out_mode == 2'd2 && int'(out_up_port) < NUM_SEC - 1);

    p_descend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && same && pkt_glob |=>
            out_mode == 2'd3 && out_eff_dst == $past(dst_id[LOC_W-1:0]));

    p_port_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode != 2'd2 |-> out_up_port == '0);

    p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_mode)
                      && $stable(out_eff_dst) && $stable(out_up_port));
endmodule

bind tier_route_sel tier_route_sel_chk #(
    .NUM_SEC(NUM_SEC), .SEC_NODES(SEC_NODES), .HUB_IDX(HUB_IDX)
) u_chk (.*);

// File: tb/tier_route_sel_bench.sv
`timescale 1ns/1ps
module tier_route_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] cur_id = '0, dst_id = '0;
    logic       pkt_glob = 1'b0;
    logic       out_valid;
    logic [1:0] out_mode;
    logic [3:0] out_eff_dst;
    logic [1:0] out_up_port;

    int total = 0, bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       v;
        logic [1:0] mode;
        logic [3:0] eff;
        logic [1:0] port;
        string      req;
    } exp_t;
    exp_t q[$];
    exp_t last;

    tier_route_sel u_tier_route_sel (.*);

    always #2 clk = ~clk;

    task automatic compare(exp_t e);
        total++;
        if (out_valid !== e.v || out_mode !== e.mode ||
            out_eff_dst !== e.eff || out_up_port !== e.port) begin
            bad++;
            $display("FAIL %s: actual v=%0b mode=%0d eff=%0d port=%0d expected v=%0b mode=%0d eff=%0d port=%0d",
                     e.req, out_valid, out_mode, out_eff_dst, out_up_port,
                     e.v, e.mode, e.eff, e.port);
        end
    endtask

    // Monitor: one result per clock, compared shortly after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) compare(q.pop_front());
    end

    // Driver: drives a request at the falling edge and queues its expectation.
    task automatic drive(input logic v, input logic [5:0] c, input logic [5:0] d,
                         input logic g);
        exp_t e;
        @(negedge clk);
        in_valid = v; cur_id = c; dst_id = d; pkt_glob = g;
        e = last;
        e.v = v;
        if (!v) e.req = "R7 idle hold";
        else if (c[5:4] == d[5:4]) begin
            e.mode = g ? 2'd3 : 2'd0;
            e.eff  = d[3:0];
            e.port = 2'd0;
            e.req  = g ? "R5 descend R6" : "R2 local R6";
        end else if (c[3:0] == 4'd0) begin
            e.mode = 2'd2;
            e.eff  = d[3:0];
            e.port = (d[5:4] < c[5:4]) ? d[5:4] : 2'(d[5:4] - 2'd1);
            e.req  = "R4 upper tier";
        end else begin
            e.mode = 2'd1;
            e.eff  = 4'd0;
            e.port = 2'd0;
            e.req  = "R3 to hub R6";
        end
        last = e;
        q.push_back(e);
    endtask

    task automatic do_reset();
        exp_t z;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; cur_id = 6'd5; dst_id = 6'd40; pkt_glob = 1'b0;
        @(negedge clk);
        z.v = 0; z.mode = 0; z.eff = 0; z.port = 0; z.req = "R1 reset";
        compare(z);
        last = z;
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        last.v = 0; last.mode = 0; last.eff = 0; last.port = 0; last.req = "";
        repeat (2) @(negedge clk);
        begin
            exp_t z;
            z.v = 0; z.mode = 0; z.eff = 0; z.port = 0; z.req = "R1 reset";
            compare(z);
        end
        rst_n = 1'b1;
        // Directed: local, to-hub, upper tier with each port, descend.
        drive(1, 6'h13, 6'h1A, 0);   // R2
        drive(1, 6'h25, 6'h07, 0);   // R3
        drive(0, 6'h00, 6'h00, 0);   // R7 idle keeps R3 result
        drive(1, 6'h20, 6'h05, 0);   // R4 sec 2 -> 0: port 0
        drive(1, 6'h20, 6'h15, 0);   // R4 sec 2 -> 1: port 1
        drive(1, 6'h20, 6'h35, 0);   // R4 sec 2 -> 3: port 2
        drive(1, 6'h00, 6'h3F, 0);   // R4 sec 0 -> 3: port 2
        drive(1, 6'h30, 6'h2C, 0);   // R4 sec 3 -> 2: port 2
        drive(0, 6'h11, 6'h22, 1);   // R7 idle keeps port
        drive(1, 6'h3B, 6'h36, 1);   // R5
        // Hub with own-section destination: match wins over hub (R2, R5).
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 16; l++) begin
                drive(1, 6'(s * 16), 6'(s * 16 + l), 0);
                drive(1, 6'(s * 16), 6'(s * 16 + l), 1);
            end
        end
        do_reset();                   // R1 mid-run
        // Full sweep with periodic idle cycles.
        for (int c = 0; c < 64; c++) begin
            for (int d = 0; d < 64; d++) begin
                drive(1, 6'(c), 6'(d), 1'(d % 2));
                if ((c + d) % 13 == 0) drive(0, 6'(d), 6'(c), 0);
            end
        end
        drive(0, 6'h00, 6'h00, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule